// File: doc/BRIEF.md
# Dirty-Line Outbound Queue with Push Reserve

This block sits between a data cache and the system bus interface. It buffers modified lines waiting to be written out. There are two kinds of traffic. Victim lines come from the eviction path of the cache and are called castouts. Copybacks raised by snoop hits or interventions are called pushes. Both kinds live in one pool of ten slots. Each slot holds a 32-bit line address, a 256-bit line payload and a flag giving its kind.

Castouts and pushes arrive on two separate ready/valid ports. The bus side drains the pool through one ready/valid port. The admission rule never lets castouts fill the whole pool, so a snoop copyback can always find room while no push is waiting. On the drain side, a waiting push leaves ahead of any castout, so snoop responses are never stuck behind victims. Apart from that rule, lines leave in arrival order. Two counters report the total fill level and the number of castouts held.

Top module: `castpush_queue`

## Requirements
- R1: A synchronous active-high reset empties the pool. While reset is held and on the first cycle after it, `occ_total` and `occ_castout` are 0 and `dq_valid` is 0.
- R2: `occ_castout` never exceeds DEPTH-1 (9). It always equals the number of held entries whose kind flag is 0.
- R3: `co_ready` is 0 whenever 9 castouts are held. It is also 0 when the castout would fill the last slot in the same cycle that a push is accepted.
- R4: `pu_ready` is 1 exactly when `occ_total` is below DEPTH (10).
- R5: While no push is held, `pu_ready` is 1. The castout cap always leaves one slot free for a push.
- R6: While at least one push is held, `dq_valid` is 1 and the dequeue port presents the oldest held push, with `dq_is_push` = 1.
- R7: While only castouts are held, entries leave in the order they were accepted, with `dq_is_push` = 0.
- R8: `occ_total` after an edge equals its earlier value, plus the accepted enqueues, minus an accepted dequeue (`dq_valid` and `dq_ready`). This includes cycles in which all three happen.
- R9: When a push and a castout are both accepted in one cycle, the push counts as older than the castout.
- R10: `occ_total` never exceeds DEPTH (10). The address, payload and kind presented at dequeue are the ones supplied at enqueue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| co_valid | input | 1 | Castout offered |
| co_ready | output | 1 | Castout can be accepted |
| co_addr | input | 32 | Castout line address |
| co_data | input | 256 | Castout line payload |
| pu_valid | input | 1 | Push offered |
| pu_ready | output | 1 | Push can be accepted |
| pu_addr | input | 32 | Push line address |
| pu_data | input | 256 | Push line payload |
| dq_valid | output | 1 | An entry is available to the bus |
| dq_ready | input | 1 | Bus takes the presented entry |
| dq_addr | output | 32 | Presented line address |
| dq_data | output | 256 | Presented line payload |
| dq_is_push | output | 1 | Kind of presented entry, 1 = push, 0 = castout |
| occ_total | output | 4 | Entries held |
| occ_castout | output | 4 | Castout entries held |

## Verification
The ready outputs and the dequeue outputs are combinational functions of the held state and the offered push valid. They are therefore due in the same cycle as the stimulus, and the bench compares them shortly after driving the inputs, before the next rising edge. The counters and the stored order change only at the edge that completes a handshake. The bench compares them one time unit after that edge, against a scoreboard queue that has been updated with exactly the handshakes it saw accepted. Each dequeued entry is popped from the scoreboard at the position chosen by the push-first rule and compared field by field.

// File: rtl/castpush_queue.sv
module castpush_queue #(
  parameter int DEPTH = 10,
  parameter int AW    = 32,
  parameter int DW    = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          co_valid,
  output logic          co_ready,
  input  logic [AW-1:0] co_addr,
  input  logic [DW-1:0] co_data,
  input  logic          pu_valid,
  output logic          pu_ready,
  input  logic [AW-1:0] pu_addr,
  input  logic [DW-1:0] pu_data,
  output logic          dq_valid,
  input  logic          dq_ready,
  output logic [AW-1:0] dq_addr,
  output logic [DW-1:0] dq_data,
  output logic          dq_is_push,
  output logic [$clog2(DEPTH+1)-1:0] occ_total,
  output logic [$clog2(DEPTH+1)-1:0] occ_castout
);
  localparam int CAP = DEPTH - 1;
  localparam int CW  = $clog2(DEPTH+1);
  localparam int IW  = $clog2(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] push_q;
  logic [AW-1:0] addr_n [DEPTH];
  logic [DW-1:0] data_n [DEPTH];
  logic [DEPTH-1:0] push_n;
  logic [CW-1:0] total, cocnt, base;
  logic [IW-1:0] sel;
  logic found, pu_fire, co_fire, dq_fire;

  assign pu_ready = total < CW'(DEPTH);
  assign pu_fire  = pu_valid && pu_ready;
  assign co_ready = (cocnt < CW'(CAP)) && (total + CW'(pu_fire) < CW'(DEPTH));
  assign co_fire  = co_valid && co_ready;
  assign dq_valid = total != '0;
  assign dq_fire  = dq_valid && dq_ready;

  always_comb begin
    sel = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (!found && CW'(i) < total && push_q[i]) begin
        sel = IW'(i);
        found = 1'b1;
      end
  end

  assign dq_addr    = addr_q[sel];
  assign dq_data    = data_q[sel];
  assign dq_is_push = push_q[sel] && dq_valid;
  assign base       = total - CW'(dq_fire);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (dq_fire && i >= int'(sel) && i < DEPTH-1) begin
        addr_n[i] = addr_q[i+1];
        data_n[i] = data_q[i+1];
        push_n[i] = push_q[i+1];
      end else begin
        addr_n[i] = addr_q[i];
        data_n[i] = data_q[i];
        push_n[i] = push_q[i];
      end
      if (pu_fire && CW'(i) == base) begin
        addr_n[i] = pu_addr;
        data_n[i] = pu_data;
        push_n[i] = 1'b1;
      end
      if (co_fire && CW'(i) == base + CW'(pu_fire)) begin
        addr_n[i] = co_addr;
        data_n[i] = co_data;
        push_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_n;
    data_q <= data_n;
    if (rst) begin
      push_q <= '0;
      total  <= '0;
      cocnt  <= '0;
    end else begin
      push_q <= push_n;
      total  <= base + CW'(pu_fire) + CW'(co_fire);
      cocnt  <= cocnt + CW'(co_fire) - CW'(dq_fire && !dq_is_push);
    end
  end

  assign occ_total   = total;
  assign occ_castout = cocnt;

  a_r2_castout_cap: assert property (@(posedge clk) disable iff (rst)
    occ_castout <= CW'(CAP));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ_total <= CW'(DEPTH));
  a_r3_cap_blocks: assert property (@(posedge clk) disable iff (rst)
    occ_castout == CW'(CAP) |-> !co_ready);
  a_r5_reserve: assert property (@(posedge clk) disable iff (rst)
    occ_total == occ_castout |-> pu_ready);
  a_r6_push_first: assert property (@(posedge clk) disable iff (rst)
    occ_total != occ_castout |-> dq_valid && dq_is_push);
  a_r8_count: assert property (@(posedge clk) disable iff (rst)
    !rst |=> occ_total == $past(occ_total) + CW'($past(pu_valid && pu_ready))
             + CW'($past(co_valid && co_ready)) - CW'($past(dq_valid && dq_ready)));
endmodule

// File: tb/castpush_queue_bench.sv
module castpush_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 10;

  logic clk = 0, rst = 1;
  logic co_valid = 0, pu_valid = 0, dq_ready = 0;
  logic [31:0] co_addr = 0, pu_addr = 0;
  logic [255:0] co_data = 0, pu_data = 0;
  logic co_ready, pu_ready, dq_valid, dq_is_push;
  logic [31:0] dq_addr;
  logic [255:0] dq_data;
  logic [3:0] occ_total, occ_castout;

  typedef struct packed { logic [31:0] a; logic p; } ent_t;
  ent_t model[$];
  int checks = 0, errors = 0;

  castpush_queue u_castpush_queue (
    .clk(clk), .rst(rst),
    .co_valid(co_valid), .co_ready(co_ready), .co_addr(co_addr), .co_data(co_data),
    .pu_valid(pu_valid), .pu_ready(pu_ready), .pu_addr(pu_addr), .pu_data(pu_data),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_addr(dq_addr), .dq_data(dq_data),
    .dq_is_push(dq_is_push), .occ_total(occ_total), .occ_castout(occ_castout));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [255:0] mk(input logic [31:0] a);
    return {8{a ^ 32'h5a5a_0f0f}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ncast();
    int n = 0;
    foreach (model[i]) if (!model[i].p) n++;
    return n;
  endfunction

  task automatic step(input bit cv, input logic [31:0] ca, input bit pv, input logic [31:0] pa, input bit dr);
    bit exp_pr, exp_cr;
    int sel;
    co_valid = cv; co_addr = ca; co_data = mk(ca);
    pu_valid = pv; pu_addr = pa; pu_data = mk(pa);
    dq_ready = dr;
    #1;
    exp_pr = model.size() < DEPTH;
    exp_cr = ncast() < DEPTH-1 && (model.size() + ((pv && exp_pr) ? 1 : 0)) < DEPTH;
    check(pu_ready == exp_pr, "R4", 256'(pu_ready), 256'(exp_pr));
    check(co_ready == exp_cr, "R3", 256'(co_ready), 256'(exp_cr));
    check(dq_valid == (model.size() > 0), "R6", 256'(dq_valid), 256'(model.size() > 0));
    if (model.size() > 0) begin
      sel = 0;
      foreach (model[i]) if (model[i].p) begin sel = i; break; end
      if (model[sel].p) begin
        check(dq_is_push && dq_addr == model[sel].a, "R6", 256'(dq_addr), 256'(model[sel].a));
      end else begin
        check(!dq_is_push && dq_addr == model[sel].a, "R7", 256'(dq_addr), 256'(model[sel].a));
      end
      check(dq_data == mk(model[sel].a), "R10", dq_data, mk(model[sel].a));
      if (dr) model.delete(sel);
    end
    if (pv && exp_pr) model.push_back('{a: pa, p: 1'b1});
    if (cv && exp_cr) model.push_back('{a: ca, p: 1'b0});
    @(posedge clk); #1;
    check(occ_total == 4'(model.size()), "R8", 256'(occ_total), 256'(model.size()));
    check(occ_castout == 4'(ncast()), "R2", 256'(occ_castout), 256'(ncast()));
  endtask

  task automatic do_reset();
    rst = 1; co_valid = 1; pu_valid = 1; dq_ready = 1;
    @(posedge clk); #1;
    check(occ_total == 0 && occ_castout == 0 && !dq_valid, "R1", 256'(occ_total), 256'(0));
    @(posedge clk); #1;
    rst = 0; co_valid = 0; pu_valid = 0; dq_ready = 0;
    model.delete();
    @(posedge clk); #1;
    check(occ_total == 0 && occ_castout == 0 && !dq_valid, "R1", 256'(occ_total), 256'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R7: castouts leave in arrival order
    for (int i = 0; i < 3; i++) step(1, 32'h100 + i, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
    // R3: cap at 9 castouts, R5: push still admitted
    for (int i = 0; i < 11; i++) step(1, 32'h200 + i, 0, 0, 0);
    check(!co_ready && occ_castout == 9, "R3", 256'(occ_castout), 256'(9));
    check(pu_ready, "R5", 256'(pu_ready), 256'(1));
    step(0, 0, 1, 32'h300, 0);
    step(0, 0, 1, 32'h301, 0);
    check(occ_total == 10 && !pu_ready, "R4", 256'(occ_total), 256'(10));
    // R6: the push leaves first, then castouts in order
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1);
    // R9: at 9 held with 8 castouts, push wins the last slot over a castout
    step(0, 0, 1, 32'h400, 0);
    for (int i = 0; i < 8; i++) step(1, 32'h500 + i, 0, 0, 0);
    step(1, 32'h600, 1, 32'h401, 0);
    check(occ_total == 10 && occ_castout == 8, "R9", 256'(occ_castout), 256'(8));
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1);
    // R9: both accepted together, push ordered first
    step(1, 32'h700, 1, 32'h701, 0);
    step(0, 0, 0, 0, 1);
    check(!dq_is_push && dq_addr == 32'h700, "R9", 256'(dq_addr), 256'(32'h700));
    step(0, 0, 0, 0, 1);
    // R8: mixed traffic with simultaneous enqueue and dequeue
    for (int i = 0; i < 400; i++)
      step(1'($urandom % 2), 32'h1000 + i, 1'($urandom % 4 == 0), 32'h8000 + i, 1'($urandom % 3 != 0));
    // R1: reset in the middle of traffic
    for (int i = 0; i < 5; i++) step(1, 32'h900 + i, 1, 32'h950 + i, 0);
    do_reset();
    step(0, 0, 0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule